// File: doc/BRIEF.md
# Framed Command Block CRC Checker

This block receives one framed block at a time as a stream of bytes and decides whether the block arrived intact. A block opens with a length byte, which gives the total size of the block. The length counts the length byte itself, every packet byte and the two check bytes. Packet bytes follow the length byte. The block closes with a two-byte CRC-16. The checker runs the CRC over the length byte and the packet bytes, then compares the result with the closing pair. It reports a one-cycle completion pulse, a pass flag, a length-fault flag and the packet length.

Bytes enter through a valid/ready port. A start strobe marks the length byte. Packet bytes are forwarded unchanged on a downstream valid/ready port, and the downstream ready backpressures the input only while a packet byte is waiting. The length byte and the check bytes are consumed inside the block and are never forwarded.

Top module: `blk_frame_chk`

## Requirements
- R1: A byte accepted with `in_sob` high is the length byte N of a new block. In the cycle after it is accepted, `pkt_len` shows N-3.
- R2: A length byte below 4 or above 39 sets `len_err` and clears `pkt_len` to 0 in the cycle after it is accepted. The bytes that follow produce no `done`, no `crc_ok` and no forwarded output until the next start.
- R3: The CRC register is 16 bits wide and starts at 0x0000 at each start. Each byte is shifted in bit 0 first. For each bit, the feedback is the data bit XOR register bit 15. The register then shifts left one place and is XORed with 0x8005 when the feedback is 1. Only the length byte and the packet bytes are shifted in.
- R4: Byte N-2 (zero-based) of a block is the low byte of the expected CRC and byte N-1 is the high byte. In the cycle after byte N-1 is accepted, `done` is high for exactly one cycle. In that same cycle, `crc_ok` is 1 exactly when the high:low pair equals the register from R3.
- R5: `crc_ok` and `len_err` keep their values until the next length byte is accepted. Both read 0 in the cycle after that length byte is accepted, unless R2 sets `len_err`.
- R6: Bytes 1 to N-3 of a legal block are forwarded. For each one, `out_valid` equals `in_valid` and `out_data` equals `in_data` in the same cycle. `out_valid` stays 0 for the length byte and for both CRC bytes.
- R7: While a packet byte is presented, `in_ready` equals `out_ready`. For every other byte, `in_ready` is 1.
- R8: A start strobe in the middle of a block abandons that block with no `done`, and restarts the byte count and the CRC from the new length byte.
- R9: A byte that arrives without `in_sob` while no legal block is open is accepted and dropped. It is not forwarded and it changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte can be taken this cycle |
| in_data | input | 8 | Input byte |
| in_sob | input | 1 | Marks the input byte as a length byte |
| out_valid | output | 1 | Forwarded packet byte present |
| out_ready | input | 1 | Downstream can take the packet byte |
| out_data | output | 8 | Forwarded packet byte |
| done | output | 1 | One-cycle pulse when a block has completed |
| crc_ok | output | 1 | The last completed block matched its CRC |
| len_err | output | 1 | The last length byte was out of range |
| pkt_len | output | 8 | Packet length of the current block (N-3) |

## Verification
The forwarding outputs and `in_ready` are combinational on the current input byte, so the bench reads them in the same cycle the byte is presented, after it has driven the inputs on the falling edge. The status outputs pass through one register. `pkt_len` and `len_err` settle in the cycle after the length byte is accepted, and `done` and `crc_ok` settle in the cycle after the last CRC byte is accepted. The bench therefore reads them a few nanoseconds after that accepting edge and well before the next one. To check that `done` lasts one cycle and that `crc_ok` holds, the bench reads both again one clock later.

// File: rtl/blk_frame_pkg.sv
package blk_frame_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BODY = 1'b1
   } frame_st_e;

   localparam int BYTE_W  = 8;
   localparam int CRC_W   = 16;
   localparam int TRAILER = 2;
endpackage

// File: rtl/blk_crc_step.sv
module blk_crc_step #(
   parameter int            DW        = 8,
   parameter int            CW        = 16,
   parameter logic [CW-1:0] POLY      = 16'h8005,
   parameter bit            LSB_FIRST = 1'b1
) (
   input  logic [CW-1:0] crc_in,
   input  logic [DW-1:0] data,
   output logic [CW-1:0] crc_out
);
   logic [CW-1:0] stage [DW+1];
   logic [DW-1:0] fb;

   assign stage[0] = crc_in;

   for (genvar i = 0; i < DW; i++) begin : g_bit
      logic dbit;
      if (LSB_FIRST) begin : g_lsb
         assign dbit = data[i];
      end else begin : g_msb
         assign dbit = data[DW-1-i];
      end
      assign fb[i]      = dbit ^ stage[i][CW-1];
      assign stage[i+1] = {stage[i][CW-2:0], 1'b0} ^ (fb[i] ? POLY : '0);
   end

   assign crc_out = stage[DW];
endmodule

// File: rtl/blk_frame_seq.sv
module blk_frame_seq
   import blk_frame_pkg::*;
#(
   parameter int            DW       = 8,
   parameter int            CW       = 16,
   parameter int            MIN_LEN  = 4,
   parameter int            MAX_LEN  = 39,
   parameter logic [CW-1:0] CRC_INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc,
   input  logic          in_sob,
   input  logic [DW-1:0] in_data,
   input  logic [CW-1:0] crc_next,
   output logic [CW-1:0] crc_base,
   output logic          pay_pos,
   output logic          done,
   output logic          crc_ok,
   output logic          len_err,
   output logic [DW-1:0] pkt_len
);
   localparam logic [DW-1:0] MIN_B  = DW'(MIN_LEN);
   localparam logic [DW-1:0] MAX_B  = DW'(MAX_LEN);
   localparam logic [DW-1:0] TAIL_B = DW'(TRAILER);
   localparam logic [DW-1:0] OVH_B  = DW'(TRAILER + 1);

   frame_st_e     st_q;
   logic [DW-1:0] pos_q, len_q, lo_q;
   logic [CW-1:0] crc_q;
   logic          bad_len;

   assign crc_base = in_sob ? CRC_INIT : crc_q;
   assign pay_pos  = (st_q == ST_BODY) && !in_sob && (pos_q < len_q - TAIL_B);
   assign bad_len  = (in_data < MIN_B) || (in_data > MAX_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         pos_q   <= '0;
         len_q   <= '0;
         lo_q    <= '0;
         crc_q   <= CRC_INIT;
         done    <= 1'b0;
         crc_ok  <= 1'b0;
         len_err <= 1'b0;
         pkt_len <= '0;
      end else begin
         done <= 1'b0;
         if (acc && in_sob) begin
            crc_q  <= crc_next;
            crc_ok <= 1'b0;
            pos_q  <= DW'(1);
            len_q  <= in_data;
            if (bad_len) begin
               st_q    <= ST_IDLE;
               len_err <= 1'b1;
               pkt_len <= '0;
            end else begin
               st_q    <= ST_BODY;
               len_err <= 1'b0;
               pkt_len <= in_data - OVH_B;
            end
         end else if (acc && st_q == ST_BODY) begin
            pos_q <= pos_q + DW'(1);
            if (pos_q < len_q - TAIL_B) begin
               crc_q <= crc_next;
            end else if (pos_q == len_q - TAIL_B) begin
               lo_q <= in_data;
            end else begin
               done   <= 1'b1;
               crc_ok <= ({in_data, lo_q} == crc_q);
               st_q   <= ST_IDLE;
            end
         end
      end
   end

   // R4: completion is a single-cycle pulse
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: a length fault never reports a pass or a completion
   p_lenerr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |-> (!crc_ok && !done));

   // R5: crc_ok only moves on a completion or after a new length byte
   p_ok_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(crc_ok) |-> (done || $past(acc && in_sob)));

   // R1: an open block always has a legal length and a position inside it
   p_len_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BODY) |-> (len_q >= MIN_B && len_q <= MAX_B && pos_q < len_q));
endmodule

// File: rtl/blk_frame_chk.sv
module blk_frame_chk
   import blk_frame_pkg::*;
#(
   parameter int                DW        = BYTE_W,
   parameter int                CW        = CRC_W,
   parameter int                MIN_LEN   = 4,
   parameter int                MAX_LEN   = 39,
   parameter logic [CRC_W-1:0]  POLY      = 16'h8005,
   parameter logic [CRC_W-1:0]  CRC_INIT  = 16'h0000,
   parameter bit                LSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_data,
   input  logic          in_sob,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data,
   output logic          done,
   output logic          crc_ok,
   output logic          len_err,
   output logic [DW-1:0] pkt_len
);
   if (CW != TRAILER * DW) begin : g_bad_width
      $error("CRC width must equal two data bytes");
   end
   if (MIN_LEN < TRAILER + 2 || MAX_LEN < MIN_LEN || MAX_LEN > (1 << DW) - 1) begin : g_bad_len
      $error("length bounds out of range");
   end

   logic          acc, pay_pos;
   logic [CW-1:0] crc_base, crc_next;

   assign in_ready  = !pay_pos || out_ready;
   assign acc       = in_valid && in_ready;
   assign out_valid = in_valid && pay_pos;
   assign out_data  = in_data;

   blk_crc_step #(
      .DW(DW), .CW(CW), .POLY(POLY), .LSB_FIRST(LSB_FIRST)
   ) u_crc (
      .crc_in (crc_base),
      .data   (in_data),
      .crc_out(crc_next)
   );

   blk_frame_seq #(
      .DW(DW), .CW(CW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .CRC_INIT(CRC_INIT)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc),
      .in_sob  (in_sob),
      .in_data (in_data),
      .crc_next(crc_next),
      .crc_base(crc_base),
      .pay_pos (pay_pos),
      .done    (done),
      .crc_ok  (crc_ok),
      .len_err (len_err),
      .pkt_len (pkt_len)
   );

   // R6: a forwarded byte is handed over in the cycle the downstream takes it
   p_fwd_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |-> acc);

   // R7: non-packet bytes are never held back
   p_ready_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !out_valid) |-> in_ready);
endmodule

// File: tb/sim_blk_frame_chk.sv
`timescale 1ns/1ps
module sim_blk_frame_chk;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_sob = 1'b0, out_ready = 1'b1;
   logic [7:0] in_data = '0;
   logic       in_ready, out_valid, done, crc_ok, len_err;
   logic [7:0] out_data, pkt_len;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] blk[$];

   always #10 clk = ~clk;

   blk_frame_chk u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_sob(in_sob), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .done(done),
      .crc_ok(crc_ok), .len_err(len_err), .pkt_len(pkt_len)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_over(input int cnt);
      logic [15:0] c = 16'h0000;
      for (int i = 0; i < cnt; i++) begin
         for (int b = 0; b < 8; b++) begin
            logic f;
            f = blk[i][b] ^ c[15];
            c = {c[14:0], 1'b0} ^ (f ? 16'h8005 : 16'h0000);
         end
      end
      return c;
   endfunction

   task automatic build(input int n, input int seed);
      logic [15:0] c;
      blk.delete();
      blk.push_back(8'(n));
      for (int i = 1; i <= n - 3; i++) blk.push_back(8'(seed * 7 + i * 13));
      c = crc_over(n - 2);
      blk.push_back(c[7:0]);
      blk.push_back(c[15:8]);
   endtask

   // drive at the falling edge, check combinational outputs, release after the accepting edge
   task automatic send_byte(input logic [7:0] d, input bit sob, input bit is_pkt, input int stall);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_sob = sob;
      for (int s = 0; s < stall; s++) begin
         out_ready = 1'b0;
         #1;
         chk(in_ready == is_pkt ? 1'b0 : 1'b1, "R7 ready under stall", in_ready, is_pkt ? 0 : 1);
         @(negedge clk);
      end
      out_ready = 1'b1;
      #1;
      chk(in_ready == 1'b1, "R7 ready free", in_ready, 1);
      if (is_pkt) chk(out_valid && out_data == d, "R6 forward", out_data, d);
      else        chk(!out_valid, "R6/R9 not forwarded", out_valid, 0);
      @(posedge clk);
      #1;
      in_valid = 1'b0; in_sob = 1'b0;
   endtask

   task automatic run_block(input int n, input int seed, input bit swap, input int stall);
      logic [15:0] c;
      logic [7:0]  t;
      bit          exp_ok;
      build(n, seed);
      if (swap) begin t = blk[n-2]; blk[n-2] = blk[n-1]; blk[n-1] = t; end
      c = crc_over(n - 2);
      exp_ok = ({blk[n-1], blk[n-2]} == c);
      for (int i = 0; i < n; i++) begin
         bit p;
         p = (i >= 1) && (i <= n - 3);
         send_byte(blk[i], i == 0, p, p ? stall : 0);
         #4;
         if (i == 0) begin
            chk(pkt_len == 8'(n - 3), "R1 pkt_len", pkt_len, n - 3);
            chk(!crc_ok && !len_err, "R5 cleared on start", {crc_ok, len_err}, 0);
         end
         if (i < n - 1) chk(!done, "R4 no early done", done, 0);
      end
      chk(done == 1'b1, "R4 done pulse", done, 1);
      chk(crc_ok == exp_ok, "R3/R4 crc_ok", crc_ok, exp_ok);
      @(posedge clk); #5;
      chk(!done, "R4 done one cycle", done, 0);
      chk(crc_ok == exp_ok, "R5 crc_ok held", crc_ok, exp_ok);
   endtask

   task automatic t_reset;
      chk(!done && !crc_ok && !len_err && pkt_len == 0, "R5 reset state",
          {done, crc_ok, len_err}, 0);
      chk(!out_valid && in_ready, "R7 reset ready", in_ready, 1);
   endtask

   task automatic t_bad_len(input int n);
      logic prev_ok;
      prev_ok = crc_ok;
      send_byte(8'(n), 1'b1, 1'b0, 0);
      #4;
      chk(len_err == 1'b1, "R2 len_err", len_err, 1);
      chk(pkt_len == 0, "R2 pkt_len zero", pkt_len, 0);
      chk(!crc_ok, "R2 no crc_ok", crc_ok, 0);
      for (int i = 0; i < 5; i++) begin
         send_byte(8'(i * 3 + 1), 1'b0, 1'b0, 0);
         #4;
         chk(!done && !crc_ok, "R2 bytes after fault ignored", done, 0);
      end
      chk(len_err == 1'b1, "R5 len_err held", len_err, 1);
      if (prev_ok) chk(1'b1, "R2", 0, 0);
   endtask

   task automatic t_stray;
      logic prev_ok;
      prev_ok = crc_ok;
      for (int i = 0; i < 3; i++) begin
         send_byte(8'(i + 40), 1'b0, 1'b0, 0);
         #4;
         chk(!done && crc_ok == prev_ok, "R9 stray byte dropped", crc_ok, prev_ok);
      end
   endtask

   task automatic t_restart;
      build(12, 5);
      for (int i = 0; i < 4; i++) begin
         send_byte(blk[i], i == 0, i >= 1, 0);
         #4;
         chk(!done, "R8 partial block no done", done, 0);
      end
      run_block(6, 9, 1'b0, 0);
      chk(crc_ok == 1'b1, "R8 restart good block", crc_ok, 1);
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      t_reset();
      rst_n = 1'b1;
      @(posedge clk); #5;
      run_block(4, 1, 1'b0, 0);
      run_block(20, 2, 1'b0, 0);
      run_block(39, 3, 1'b0, 0);
      t_stray();
      run_block(10, 4, 1'b1, 0);
      run_block(8, 6, 1'b0, 2);
      t_bad_len(3);
      t_bad_len(40);
      run_block(5, 11, 1'b0, 1);
      t_restart();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule